// File: doc/BRIEF.md
# Programmable AND-OR Product-Term Array

This block is the two-level logic core of a small field-configurable logic device. Each of its logical inputs is presented to the array in both true and inverted form. A bank of product terms can each connect to any subset of those lines and form the AND of whatever it is connected to. Most of the terms are grouped into per-output OR sums. The group sizes are uneven: the first few outputs own a wider group of terms and the rest own a narrower group. Each output also has one dedicated term that serves as its enable, and the array has two global terms meant to drive an asynchronous preset and an asynchronous reset downstream.

The connection pattern sits in a single configuration shift chain, one bit per term per line, loaded one bit per clock while the shift enable is high. Evaluation does not use the clock: every output follows the inputs and the stored pattern combinationally. Reset returns every connection to the connected state. In that state each term holds an input together with its own complement, so every output is 0 until a pattern is loaded.

With the defaults the array has 20 inputs (40 lines) and 90 terms. Outputs 0 to 3 own 12 terms each and outputs 4 to 7 own 8 each. That makes 80 sum terms, 8 enable terms and the preset and reset terms, for a 3600-bit chain.

Top module: `pta_core`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets every configuration bit to 1 (connected). With the chain in that state all sums, enable terms, preset and reset are 0 for every input value.
- R2: On each rising clock edge with cfg_shift_en high the chain moves one place toward higher bit index and cfg_sdi enters bit 0. With cfg_shift_en low, cfg_sdi has no effect and the chain holds. After a full load of CHAIN bits, the first bit shifted in sits at the top index and the last one sits at bit 0.
- R3: Line 2i carries in_vec[i] and line 2i+1 carries its complement. Term t reads chain bits [t*LINES +: LINES], and bit l connects line l when it is 1. The term is the AND of its connected lines, and a term with no connections is 1.
- R4: A term that has both lines of the same input connected is 0 for every input value.
- R5: Sum terms are numbered by output index first, then by term index within the output. Outputs below NUM_WIDE own WIDE_TERMS terms starting at o*WIDE_TERMS. Each later output owns NARROW_TERMS terms starting at NUM_WIDE*WIDE_TERMS+(o-NUM_WIDE)*NARROW_TERMS. sum_out[o] is the OR of the terms it owns.
- R6: The enable term of output o is term SUM_TERMS+o and drives oe_term[o]. An enable term with no connections holds its output enabled permanently.
- R7: preset_term is term SUM_TERMS+NUM_OUT and reset_term is the last term.
- R8: All outputs are combinational functions of in_vec and the stored chain. A change on in_vec appears with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset; sets all connections |
| cfg_shift_en | input | 1 | Shift the configuration chain by one place this clock |
| cfg_sdi | input | 1 | Serial bit entering chain bit 0 |
| in_vec | input | NUM_IN | Logical inputs to the array |
| sum_out | output | NUM_OUT | OR sum of each output's product terms |
| oe_term | output | NUM_OUT | Per-output enable product term |
| preset_term | output | 1 | Global preset product term |
| reset_term | output | 1 | Global reset product term |

## Verification
On every cycle the assertions check that the chain holds when shifting is off and advances by exactly one place when it is on. They check that a fully connected term and a term holding both polarities of one input are 0. They also check that with the chain quiet and the inputs steady, no output moves. Only the bench's scenarios can show that the term-to-output grouping, the placement of the enable, preset and reset terms and the line polarity match the requirements. The bench does this with a reduced four-input build: it loads complete patterns and sweeps every input value against an arithmetic model.

// File: rtl/pta_pkg.sv
package pta_pkg;

    // First sum term owned by output o
    function automatic int sum_base(input int o, input int n_wide,
                                    input int wide_t, input int narrow_t);
        if (o < n_wide)
            return o * wide_t;
        return n_wide * wide_t + (o - n_wide) * narrow_t;
    endfunction

    // Number of sum terms owned by output o
    function automatic int sum_count(input int o, input int n_wide,
                                     input int wide_t, input int narrow_t);
        return (o < n_wide) ? wide_t : narrow_t;
    endfunction

endpackage

// File: rtl/pta_cfg_chain.sv
module pta_cfg_chain #(
    parameter int DEPTH = 3600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sdi,
    output logic [DEPTH-1:0] cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg <= '1;
        else if (shift_en)
            cfg <= {cfg[DEPTH-2:0], sdi};
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cfg));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cfg[DEPTH-1:1] == $past(cfg[DEPTH-2:0])));

    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cfg[0] == $past(sdi)));

endmodule

// File: rtl/pta_pterm.sv
module pta_pterm #(
    parameter int LINES = 40
) (
    input  logic [LINES-1:0] conn,
    input  logic [LINES-1:0] lines,
    output logic             term
);

    localparam int NUM_IN = LINES / 2;

    // A line that is not connected contributes 1 to the AND
    always_comb term = &(~conn | lines);

    always_comb begin
        if (&conn)
            p_intact_off_r1: assert (!term);
        for (int i = 0; i < NUM_IN; i++) begin
            if (conn[2*i] && conn[2*i+1])
                p_contra_r4: assert (!term);
        end
    end

endmodule

// File: rtl/pta_or_sum.sv
module pta_or_sum #(
    parameter int N = 8
) (
    input  logic [N-1:0] terms,
    output logic         sum
);

    always_comb sum = |terms;

endmodule

// File: rtl/pta_core.sv
module pta_core #(
    parameter int NUM_IN       = 20,
    parameter int NUM_OUT      = 8,
    parameter int NUM_WIDE     = 4,
    parameter int WIDE_TERMS   = 12,
    parameter int NARROW_TERMS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_shift_en,
    input  logic               cfg_sdi,
    input  logic [NUM_IN-1:0]  in_vec,
    output logic [NUM_OUT-1:0] sum_out,
    output logic [NUM_OUT-1:0] oe_term,
    output logic               preset_term,
    output logic               reset_term
);

    import pta_pkg::*;

    localparam int LINES     = 2 * NUM_IN;
    localparam int SUM_TERMS = NUM_WIDE * WIDE_TERMS
                             + (NUM_OUT - NUM_WIDE) * NARROW_TERMS;
    localparam int TERMS     = SUM_TERMS + NUM_OUT + 2;
    localparam int CHAIN     = TERMS * LINES;

    logic [LINES-1:0] lines;
    logic [CHAIN-1:0] cfg_q;
    logic [TERMS-1:0] term_v;

    // true / complement line pairs
    for (genvar i = 0; i < NUM_IN; i++) begin : g_line
        assign lines[2*i]   = in_vec[i];
        assign lines[2*i+1] = ~in_vec[i];
    end

    pta_cfg_chain #(.DEPTH(CHAIN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .sdi      (cfg_sdi),
        .cfg      (cfg_q)
    );

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        pta_pterm #(.LINES(LINES)) u_term (
            .conn  (cfg_q[t*LINES +: LINES]),
            .lines (lines),
            .term  (term_v[t])
        );
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
        localparam int BASE = sum_base(o, NUM_WIDE, WIDE_TERMS, NARROW_TERMS);
        localparam int CNT  = sum_count(o, NUM_WIDE, WIDE_TERMS, NARROW_TERMS);
        pta_or_sum #(.N(CNT)) u_or (
            .terms (term_v[BASE +: CNT]),
            .sum   (sum_out[o])
        );
    end

    assign oe_term     = term_v[SUM_TERMS +: NUM_OUT];
    assign preset_term = term_v[TERMS-2];
    assign reset_term  = term_v[TERMS-1];

    p_static_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift_en |=> (!$stable(in_vec) ||
            $stable({sum_out, oe_term, preset_term, reset_term})));

endmodule

// File: tb/pta_core_test.sv
module pta_core_test;

    localparam int NI = 4;
    localparam int NO = 8;
    localparam int NW = 4;
    localparam int WT = 12;
    localparam int NT = 8;
    localparam int LN = 2 * NI;
    localparam int ST = NW * WT + (NO - NW) * NT;
    localparam int TT = ST + NO + 2;
    localparam int CH = TT * LN;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_shift_en;
    logic          cfg_sdi;
    logic [NI-1:0] in_vec;
    logic [NO-1:0] sum_out;
    logic [NO-1:0] oe_term;
    logic          preset_term;
    logic          reset_term;

    logic [CH-1:0] img;
    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int seed  = 12345;

    always #5 clk = ~clk;

    pta_core #(.NUM_IN(NI), .NUM_OUT(NO), .NUM_WIDE(NW),
               .WIDE_TERMS(WT), .NARROW_TERMS(NT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en),
        .cfg_sdi(cfg_sdi), .in_vec(in_vec), .sum_out(sum_out),
        .oe_term(oe_term), .preset_term(preset_term), .reset_term(reset_term)
    );

    function automatic int base_of(int o);
        return (o < NW) ? o * WT : NW * WT + (o - NW) * NT;
    endfunction

    function automatic int cnt_of(int o);
        return (o < NW) ? WT : NT;
    endfunction

    function automatic logic term_of(int t, logic [NI-1:0] x);
        logic [LN-1:0] ln;
        logic [LN-1:0] c;
        for (int i = 0; i < NI; i++) begin
            ln[2*i]   = x[i];
            ln[2*i+1] = ~x[i];
        end
        c = img[t*LN +: LN];
        return &(~c | ln);
    endfunction

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (in=%b)", tag, act, exp, in_vec);
        end
    endtask

    task automatic load_image();
        for (int b = CH - 1; b >= 0; b--) begin
            @(negedge clk);
            cfg_shift_en = 1'b1;
            cfg_sdi      = img[b];
        end
        @(negedge clk);
        cfg_shift_en = 1'b0;
        cfg_sdi      = 1'b0;
    endtask

    // R3 R5 R6 R7: every input value against the model of img
    task automatic sweep_model();
        logic [NO-1:0] es;
        logic [NO-1:0] eo;
        for (int v = 0; v < (1 << NI); v++) begin
            @(negedge clk);
            in_vec = v[NI-1:0];
            #1;
            for (int o = 0; o < NO; o++) begin
                es[o] = 1'b0;
                for (int k = 0; k < cnt_of(o); k++)
                    es[o] = es[o] | term_of(base_of(o) + k, in_vec);
                eo[o] = term_of(ST + o, in_vec);
            end
            check("R5 R3 sums", 16'(sum_out), 16'(es));
            check("R6 enables", 16'(oe_term), 16'(eo));
            check("R7 preset/reset", {14'd0, preset_term, reset_term},
                  {14'd0, term_of(TT - 2, in_vec), term_of(TT - 1, in_vec)});
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        cfg_shift_en = 1'b0;
        cfg_sdi      = 1'b0;
        in_vec       = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared chain gives all zero outputs
        for (int v = 0; v < (1 << NI); v++) begin
            @(negedge clk);
            in_vec = v[NI-1:0];
            #1;
            check("R1 cleared", {sum_out, oe_term}, 16'h0000);
            check("R1 cleared globals", {14'd0, preset_term, reset_term}, 16'h0);
        end

        // Hand-built pattern: boundary terms, empty and contradictory terms
        img = '1;
        img[(base_of(0) + 11) * LN +: LN] = 8'b0000_1001; // in0 & ~in1
        img[(base_of(7) + 7) * LN +: LN]  = 8'b1000_0000; // ~in3
        img[(ST + 0) * LN +: LN]          = 8'b0000_0000; // empty: always 1
        img[(TT - 2) * LN +: LN]          = 8'b0011_0000; // in2 & ~in2
        img[(TT - 1) * LN +: LN]          = 8'b0001_0000; // in2
        load_image();
        for (int v = 0; v < (1 << NI); v++) begin
            logic [NO-1:0] es;
            @(negedge clk);
            in_vec = v[NI-1:0];
            #1;
            es    = '0;
            es[0] = in_vec[0] & ~in_vec[1];
            es[7] = ~in_vec[3];
            check("R5 last wide/narrow term", 16'(sum_out), 16'(es));
            check("R6 empty enable term", 16'(oe_term), 16'h0001);
            check("R4 contradictory preset", {15'd0, preset_term}, 16'h0);
            check("R7 reset term", {15'd0, reset_term}, {15'd0, in_vec[2]});
        end
        sweep_model();

        // Pseudo-random patterns swept exhaustively
        for (int rep = 0; rep < 3; rep++) begin
            img = '1;
            for (int t = 0; t < TT; t++) begin
                logic [LN-1:0] c;
                c = '0;
                for (int i = 0; i < NI; i++) begin
                    int s;
                    s = next_rand() % 5;
                    if (s == 1) c[2*i]   = 1'b1;
                    if (s == 2) c[2*i+1] = 1'b1;
                end
                if ((next_rand() % 4) != 0)
                    img[t*LN +: LN] = c;
            end
            load_image();
            sweep_model();
        end

        // R2: shift disabled, toggling cfg_sdi changes nothing
        @(negedge clk);
        in_vec = 4'b1010;
        #1;
        begin
            logic [2*NO+1:0] snap;
            snap = {sum_out, oe_term, preset_term, reset_term};
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                cfg_sdi = c[0];
                #1;
                total++;
                if ({sum_out, oe_term, preset_term, reset_term} !== snap) begin
                    bad++;
                    $display("FAIL R2 hold: actual=%h expected=%h",
                             {sum_out, oe_term, preset_term, reset_term}, snap);
                end
            end
        end
        sweep_model();

        // R2: one extra shift moves every bit up one place
        @(negedge clk);
        cfg_shift_en = 1'b1;
        cfg_sdi      = 1'b0;
        @(negedge clk);
        cfg_shift_en = 1'b0;
        img = {img[CH-2:0], 1'b0};
        sweep_model();

        // R8: outputs follow inputs between clock edges
        img = '1;
        img[(base_of(3)) * LN +: LN] = 8'b0000_0001; // out3 = in0
        load_image();
        @(posedge clk);
        #2;
        in_vec = 4'b0001;
        #1;
        check("R8 comb rise", {15'd0, sum_out[3]}, 16'h1);
        in_vec = 4'b0000;
        #1;
        check("R8 comb fall", {15'd0, sum_out[3]}, 16'h0);

        // R1: reset mid-run clears the pattern again
        @(negedge clk);
        rst_n = 1'b0;
        in_vec = 4'b0001;
        #1;
        check("R1 async reset", {sum_out, oe_term}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule